// File: doc/BRIEF.md
# Accumulator logic and rotate execution unit

This unit executes the bitwise and rotate group of an 8-bit accumulator machine. Each cycle with `valid_i` high it takes an operation code, the current accumulator, a fetched operand byte, an immediate byte and the carry flag. One cycle later it presents the result, a destination select, the new carry and a one-cycle write strobe. Operand fetch, address decode, sequencing and the storage arrays sit outside the unit.

Some logic operations return their result to the accumulator. In that case the second operand is whatever byte the fetch stage supplied on `opnd_i`: a register, a direct byte, an indirect byte or immediate data. Other logic operations read a direct byte on `opnd_i`, combine it with either the accumulator or `imm_i`, and send the result back to that direct byte. The unit also provides clear, complement, plain rotates, rotates through carry and the nibble swap, all of which act on the accumulator.

Top module: `alu_acc_unit`

## Requirements
- R1: Operation codes 0, 1 and 2 (OR, XOR, AND) produce `acc_i | opnd_i`, `acc_i ^ opnd_i` and `acc_i & opnd_i` respectively, with `dest_o` = 0 (accumulator).
- R2: The direct-destination forms put out `opnd_i` combined with a partner byte and set `dest_o` = 1 (direct byte). Code 3 is OR with the accumulator, 4 is OR with `imm_i`, 5 is XOR with the accumulator, 6 is XOR with `imm_i`, 7 is AND with the accumulator and 8 is AND with `imm_i`.
- R3: Code 9 (clear) outputs 0 and code 10 (complement) outputs `~acc_i`, both with `dest_o` = 0.
- R4: Code 11 rotates the accumulator left by one bit and code 13 rotates it right by one bit. In both the bit that leaves one end wraps to the other end, and `dest_o` = 0.
- R5: Code 12 rotates left through carry: bit 7 goes to `cy_o`, the old carry goes to bit 0, and the remaining bits shift up by one. Code 14 rotates right through carry: bit 0 goes to `cy_o`, the old carry goes to bit 7, and the remaining bits shift down by one. Both have `dest_o` = 0.
- R6: Code 15 exchanges bits 7..4 with bits 3..0 of the accumulator, with `dest_o` = 0.
- R7: For every code other than 12 and 14, `cy_o` equals the `cy_i` value sampled with the operation.
- R8: `wr_o` is high in exactly the cycle after each cycle in which `valid_i` is high, and low in every other cycle. Back-to-back operations give a continuous strobe.
- R9: While `valid_i` is low, `result_o`, `dest_o` and `cy_o` hold their last values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code (see R1 to R6) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Fetched operand or direct byte |
| imm_i | input | 8 | Immediate byte for direct-destination forms |
| cy_i | input | 1 | Carry flag in |
| result_o | output | 8 | Registered result |
| dest_o | output | 1 | 0 = accumulator, 1 = direct byte |
| cy_o | output | 1 | Registered carry out |
| wr_o | output | 1 | One-cycle write strobe |

## Verification
A rotate through carry changes the result byte and the carry in the same cycle, and the two must cross over: the bit that leaves the accumulator becomes the carry, and the old carry enters the vacated bit. The bench provokes this with operands that differ only in the end bits, such as 0x80 or 0x01 with carry 0 and 0x00 or 0xFF with carry 1. It judges `result_o` and `cy_o` together against an independent reference in the cycle after issue. The write strobe and the carry pass-through are also checked during back-to-back issue across all sixteen codes, so a carry leak or a dropped strobe between neighbouring operations shows up.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_OR_A   = 4'd0,
    OP_XOR_A  = 4'd1,
    OP_AND_A  = 4'd2,
    OP_OR_DA  = 4'd3,
    OP_OR_DI  = 4'd4,
    OP_XOR_DA = 4'd5,
    OP_XOR_DI = 4'd6,
    OP_AND_DA = 4'd7,
    OP_AND_DI = 4'd8,
    OP_CLR    = 4'd9,
    OP_CPL    = 4'd10,
    OP_RL     = 4'd11,
    OP_RLC    = 4'd12,
    OP_RR     = 4'd13,
    OP_RRC    = 4'd14,
    OP_SWAP   = 4'd15
  } op_e;

  typedef enum logic {
    DEST_ACC = 1'b0,
    DEST_DIR = 1'b1
  } dest_e;

  typedef enum logic [1:0] {
    LK_OR  = 2'd0,
    LK_XOR = 2'd1,
    LK_AND = 2'd2
  } logic_kind_e;
endpackage

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] imm_i,
  output logic [W-1:0] res_o,
  output dest_e        dest_o
);
  logic_kind_e  kind;
  logic [W-1:0] a_op, b_op;

  always_comb begin
    kind   = LK_OR;
    dest_o = DEST_DIR;
    a_op   = acc_i;
    b_op   = opnd_i;
    unique case (op_i)
      OP_OR_A:   begin kind = LK_OR;  dest_o = DEST_ACC; end
      OP_XOR_A:  begin kind = LK_XOR; dest_o = DEST_ACC; end
      OP_AND_A:  begin kind = LK_AND; dest_o = DEST_ACC; end
      OP_OR_DA:  kind = LK_OR;
      OP_OR_DI:  begin kind = LK_OR;  a_op = imm_i; end
      OP_XOR_DA: kind = LK_XOR;
      OP_XOR_DI: begin kind = LK_XOR; a_op = imm_i; end
      OP_AND_DA: kind = LK_AND;
      OP_AND_DI: begin kind = LK_AND; a_op = imm_i; end
      default:   dest_o = DEST_ACC;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (kind)
        LK_XOR:  res_o[i] = a_op[i] ^ b_op[i];
        LK_AND:  res_o[i] = a_op[i] & b_op[i];
        default: res_o[i] = a_op[i] | b_op[i];
      endcase
    end
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] acc_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  localparam int H = W / 2;

  logic [W-1:0] rl, rr, rlc, rrc, swp;

  for (genvar i = 0; i < W; i++) begin : g_rot
    if (i == 0) begin : g_lsb
      assign rl[i]  = acc_i[W-1];
      assign rlc[i] = cy_i;
      assign rr[i]  = acc_i[i+1];
      assign rrc[i] = acc_i[i+1];
    end else if (i == W-1) begin : g_msb
      assign rl[i]  = acc_i[i-1];
      assign rlc[i] = acc_i[i-1];
      assign rr[i]  = acc_i[0];
      assign rrc[i] = cy_i;
    end else begin : g_mid
      assign rl[i]  = acc_i[i-1];
      assign rlc[i] = acc_i[i-1];
      assign rr[i]  = acc_i[i+1];
      assign rrc[i] = acc_i[i+1];
    end
  end

  assign swp = {acc_i[H-1:0], acc_i[W-1:H]};

  always_comb begin
    cy_o = cy_i;
    unique case (op_i)
      OP_CLR:  res_o = '0;
      OP_CPL:  res_o = ~acc_i;
      OP_RL:   res_o = rl;
      OP_RLC:  begin res_o = rlc; cy_o = acc_i[W-1]; end
      OP_RR:   res_o = rr;
      OP_RRC:  begin res_o = rrc; cy_o = acc_i[0]; end
      OP_SWAP: res_o = swp;
      default: res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/alu_acc_unit.sv
module alu_acc_unit
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] imm_i,
  input  logic         cy_i,
  output logic [W-1:0] result_o,
  output logic         dest_o,
  output logic         cy_o,
  output logic         wr_o
);
  op_e          op;
  logic [W-1:0] lg_res, sh_res, nxt_res;
  dest_e        lg_dest, nxt_dest;
  logic         sh_cy, is_logic;

  assign op       = op_e'(op_i);
  assign is_logic = (op_i <= 4'(OP_AND_DI));

  alu_logic #(.W(W)) u_logic (
    .op_i  (op),
    .acc_i (acc_i),
    .opnd_i(opnd_i),
    .imm_i (imm_i),
    .res_o (lg_res),
    .dest_o(lg_dest)
  );

  alu_shift #(.W(W)) u_shift (
    .op_i (op),
    .acc_i(acc_i),
    .cy_i (cy_i),
    .res_o(sh_res),
    .cy_o (sh_cy)
  );

  assign nxt_res  = is_logic ? lg_res : sh_res;
  assign nxt_dest = is_logic ? lg_dest : DEST_ACC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      dest_o   <= 1'b0;
      cy_o     <= 1'b0;
      wr_o     <= 1'b0;
    end else begin
      wr_o <= valid_i;
      if (valid_i) begin
        result_o <= nxt_res;
        dest_o   <= nxt_dest;
        cy_o     <= is_logic ? cy_i : sh_cy;
      end
    end
  end

  // R1
  assert_acc_or_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_OR_A) |=> (result_o == ($past(acc_i) | $past(opnd_i)) && !dest_o));
  // R2
  assert_dir_imm_and_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_AND_DI) |=> (result_o == ($past(imm_i) & $past(opnd_i)) && dest_o));
  // R3
  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_CLR) |=> (result_o == '0));
  // R4
  assert_rl_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_RL) |=> (result_o[0] == $past(acc_i[W-1]) && result_o[W-1:1] == $past(acc_i[W-2:0])));
  // R5
  assert_rlc_cross_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_RLC) |=> (cy_o == $past(acc_i[W-1]) && result_o[0] == $past(cy_i)));
  assert_rrc_cross_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_RRC) |=> (cy_o == $past(acc_i[0]) && result_o[W-1] == $past(cy_i)));
  // R7
  assert_carry_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op != OP_RLC && op != OP_RRC) |=> (cy_o == $past(cy_i)));
  // R8
  assert_strobe_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> wr_o);
  assert_strobe_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wr_o);
  // R9
  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(dest_o) && $stable(cy_o)));
endmodule

// File: tb/tb_alu_acc_unit.sv
module tb_alu_acc_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0, imm_i = '0;
  logic       cy_i = 1'b0;
  logic [7:0] result_o;
  logic       dest_o, cy_o, wr_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  alu_acc_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .imm_i(imm_i), .cy_i(cy_i),
    .result_o(result_o), .dest_o(dest_o), .cy_o(cy_o), .wr_o(wr_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int req_of(input int op);
    if (op <= 2) return 1;
    if (op <= 8) return 2;
    if (op <= 10) return 3;
    if (op == 11 || op == 13) return 4;
    if (op == 12 || op == 14) return 5;
    return 6;
  endfunction

  // reference: {dest, carry, result}
  function automatic logic [9:0] model(input int op, input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] im, input logic c);
    logic [7:0] r;
    logic d, co;
    d = 0; co = c; r = 0;
    case (op)
      0: r = a | b;
      1: r = a ^ b;
      2: r = a & b;
      3: begin r = b | a;  d = 1; end
      4: begin r = b | im; d = 1; end
      5: begin r = b ^ a;  d = 1; end
      6: begin r = b ^ im; d = 1; end
      7: begin r = b & a;  d = 1; end
      8: begin r = b & im; d = 1; end
      9: r = 8'h00;
      10: r = 8'hFF - a;
      11: r = 8'((a * 2) + (a / 128));
      12: begin r = 8'((a * 2) + c); co = a[7]; end
      13: r = 8'((a / 2) + ((a % 2) * 128));
      14: begin r = 8'((a / 2) + (c * 128)); co = a[0]; end
      default: r = 8'(((a % 16) * 16) + (a / 16));
    endcase
    return {d, co, r};
  endfunction

  // issue one op, check the cycle after
  task automatic run_op(input int op, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] im, input logic c);
    logic [9:0] e;
    string rq;
    e = model(op, a, b, im, c);
    rq = $sformatf("R%0d", req_of(op));
    @(negedge clk_i);
    valid_i = 1; op_i = 4'(op); acc_i = a; opnd_i = b; imm_i = im; cy_i = c;
    @(negedge clk_i);
    valid_i = 0;
    chk(rq, $sformatf("result op%0d", op), result_o, e[7:0]);
    chk(rq, $sformatf("dest op%0d", op), dest_o, e[9]);
    chk((op == 12 || op == 14) ? "R5" : "R7", $sformatf("carry op%0d", op), cy_o, e[8]);
    chk("R8", "strobe", wr_o, 1);
  endtask

  task automatic t_reset();
    chk("R9", "reset result", result_o, 0);
    chk("R9", "reset dest", dest_o, 0);
    chk("R9", "reset carry", cy_o, 0);
    chk("R8", "reset strobe", wr_o, 0);
  endtask

  task automatic t_acc_logic();   // R1
    run_op(0, 8'hA5, 8'h0F, 8'h00, 0);
    run_op(1, 8'hA5, 8'hFF, 8'h00, 1);
    run_op(2, 8'hA5, 8'h3C, 8'hFF, 0);
  endtask

  task automatic t_dir_logic();   // R2
    for (int op = 3; op <= 8; op++) begin
      run_op(op, 8'hC3, 8'h5A, 8'h81, 1);
      run_op(op, 8'h00, 8'hF0, 8'hFF, 0);
    end
  endtask

  task automatic t_clr_cpl();     // R3
    run_op(9, 8'hFF, 8'h12, 8'h34, 1);
    run_op(10, 8'h6C, 8'h00, 8'h00, 0);
    run_op(10, 8'h00, 8'h00, 8'h00, 1);
  endtask

  task automatic t_rotate();      // R4
    run_op(11, 8'h81, 0, 0, 0);
    run_op(11, 8'h40, 0, 0, 1);
    run_op(13, 8'h01, 0, 0, 1);
    run_op(13, 8'h02, 0, 0, 0);
  endtask

  task automatic t_rot_carry();   // R5 corners
    run_op(12, 8'h80, 0, 0, 0);
    run_op(12, 8'h00, 0, 0, 1);
    run_op(12, 8'hFF, 0, 0, 0);
    run_op(14, 8'h01, 0, 0, 0);
    run_op(14, 8'h00, 0, 0, 1);
    run_op(14, 8'hFE, 0, 0, 1);
  endtask

  task automatic t_swap();        // R6
    run_op(15, 8'h1E, 0, 0, 0);
    run_op(15, 8'hF0, 0, 0, 1);
  endtask

  task automatic t_carry_pass();  // R7
    for (int op = 0; op < 16; op++)
      if (op != 12 && op != 14) run_op(op, 8'hFF, 8'hFF, 8'hFF, 1);
  endtask

  task automatic t_back_to_back(); // R8, R7 across neighbours
    logic [9:0] e [16];
    logic [7:0] a [16];
    logic c [16];
    for (int i = 0; i < 16; i++) begin
      a[i] = 8'($urandom_range(0, 255));
      c[i] = 1'($urandom_range(0, 1));
      e[i] = model(i, a[i], 8'h96, 8'h69, c[i]);
    end
    @(negedge clk_i);
    for (int i = 0; i < 16; i++) begin
      valid_i = 1; op_i = 4'(i); acc_i = a[i]; opnd_i = 8'h96; imm_i = 8'h69; cy_i = c[i];
      @(negedge clk_i);
      chk("R8", "continuous strobe", wr_o, 1);
      chk($sformatf("R%0d", req_of(i)), $sformatf("b2b result op%0d", i), result_o, e[i][7:0]);
      chk((i == 12 || i == 14) ? "R5" : "R7", $sformatf("b2b carry op%0d", i), cy_o, e[i][8]);
    end
    valid_i = 0;
    @(negedge clk_i);
    chk("R8", "strobe drops", wr_o, 0);
  endtask

  task automatic t_hold();        // R9
    logic [7:0] r; logic d, c;
    run_op(4, 8'h00, 8'h10, 8'h01, 1);
    r = result_o; d = dest_o; c = cy_o;
    @(negedge clk_i);
    op_i = 4'd9; acc_i = 8'h77; cy_i = 0; opnd_i = 8'h00;
    repeat (3) @(negedge clk_i);
    chk("R9", "hold result", result_o, r);
    chk("R9", "hold dest", dest_o, d);
    chk("R9", "hold carry", cy_o, c);
    chk("R8", "no strobe idle", wr_o, 0);
  endtask

  task automatic t_random();      // all codes, random operands
    for (int n = 0; n < 20; n++)
      for (int op = 0; op < 16; op++)
        run_op(op, 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
               8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_acc_logic();
    t_dir_logic();
    t_clr_cpl();
    t_rotate();
    t_rot_carry();
    t_swap();
    t_carry_pass();
    t_back_to_back();
    t_hold();
    t_random();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule